// File: doc/BRIEF.md
# Privileged Special-Register Access Controller

This block serves the two instructions a CPU uses to move data into and out of its special-purpose registers. Each access presents an address, a direction and, for writes, a data word, along with the two status-register bits that grant access: the supervisor bit and the user-access-enable bit. The block checks privilege, decodes the address against the small set of registers it holds, returns read data in the same cycle, and commits writes at the next clock edge. A warning flag marks every access that was refused or that targeted nothing usable.

The readable and writable sets differ on purpose. Identification words and the previous-PC value can be read but not written. The saved-status register can be written but not read back. The next-PC register is write-only: a write to it becomes a one-cycle redirect request that carries the new target and tells the pipeline to drop any pending delay-slot state. Writing the status register always forces its fixed-one bit. A write to the tick-timer mode register is absorbed: a zero is accepted quietly, and anything else raises the warning.

The redirect sequencer has two states. ST_IDLE is the resting state. A permitted next-PC write moves it to ST_REDIRECT, where the request is raised for one cycle. Transitions: ST_IDLE to ST_REDIRECT on a next-PC write; ST_REDIRECT to ST_REDIRECT on another next-PC write; ST_REDIRECT to ST_IDLE otherwise; ST_IDLE to ST_IDLE otherwise.

Top module: `spr_access_ctrl`

## Requirements
- R1: An access is permitted only when `sr_super` or `sr_user_spr` is 1. A refused access returns `rd_data` = 0, changes no register and raises `bad_access` in the same cycle.
- R2: Any address at or above NUM_SPR (default 0x400) is invalid. A read there returns 0, a write there has no effect, and both raise `bad_access`.
- R3: Reads are combinational. In the strobe cycle, `rd_data` holds the value at these addresses: 0x000 version constant, 0x001 unit-present constant, 0x002 configuration constant, 0x009 status, 0x00A previous PC (the `prev_pc` input), 0x00B FP control, 0x00C exception PC, 0x010 accumulator low, 0x011 accumulator high. `rd_data` is 0 in any cycle that is not a permitted read of a readable address.
- R4: The saved-status register at 0x00C+1 = 0x00D accepts writes without a warning. A read of it returns 0 and raises `bad_access`.
- R5: Writes to the read-only addresses 0x000, 0x001, 0x002 and 0x00A raise `bad_access` and leave the read value unchanged.
- R6: A write to the status register stores the data with bit 15 (the fixed-one bit) forced to 1.
- R7: A permitted write to the next-PC address 0x008 raises `redirect_req` for exactly the following cycle, with `redirect_pc` equal to the written data. A read of 0x008 returns 0 and raises `bad_access`.
- R8: A write to the timer-mode address 0x018 changes nothing. With zero data `bad_access` stays 0; with non-zero data it is 1. A read of 0x018 raises `bad_access`.
- R9: The shadow window covers 512 words at 0x100 to 0x2FF. Each word is readable and writable on its own.
- R10: In-range addresses that map to no register (for example 0x003 and 0x300) return 0 and raise `bad_access` for both reads and writes.
- R11: A write changes the register at the next rising edge. `rd_data` is 0 during the write cycle.
- R12: After reset the status register reads 0x0000_8000; the FP control, exception PC, saved-status and accumulator registers read 0; and `redirect_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Register address |
| acc_wdata | input | 32 | Write data |
| sr_super | input | 1 | Supervisor-mode bit of the status register |
| sr_user_spr | input | 1 | User access-enable bit of the status register |
| prev_pc | input | 32 | Previous-PC value, returned on reads of 0x00A |
| rd_data | output | 32 | Read data, valid in the strobe cycle |
| bad_access | output | 1 | Warning: refused, invalid or non-zero timer write |
| redirect_req | output | 1 | One-cycle request to restart fetch and clear delay-slot state |
| redirect_pc | output | 32 | Restart target while `redirect_req` is 1 |

## Verification
The assertions assume that the access inputs are known and stable around each clock edge, and that a strobe lasts exactly one cycle per access, so that a next-PC write maps onto a single redirect cycle. The bench changes every input only on the falling edge and holds it for one full cycle. It samples outputs a quarter period later, while the strobe and both privilege bits are still driven.

// File: rtl/spr_pkg.sv
package spr_pkg;

    localparam int unsigned DATA_W = 32;

    // Address map; the shadow window base and size are top-level parameters
    localparam int unsigned A_VER    = 'h000;
    localparam int unsigned A_UNIT   = 'h001;
    localparam int unsigned A_CFG    = 'h002;
    localparam int unsigned A_NPC    = 'h008;
    localparam int unsigned A_STAT   = 'h009;
    localparam int unsigned A_PPC    = 'h00A;
    localparam int unsigned A_FPC    = 'h00B;
    localparam int unsigned A_EPC    = 'h00C;
    localparam int unsigned A_ESR    = 'h00D;
    localparam int unsigned A_ACC_LO = 'h010;
    localparam int unsigned A_ACC_HI = 'h011;
    localparam int unsigned A_TMR    = 'h018;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_VER, SEL_UNIT, SEL_CFG, SEL_NPC, SEL_STAT, SEL_PPC,
        SEL_FPC, SEL_EPC, SEL_ESR, SEL_ACC_LO, SEL_ACC_HI, SEL_TMR, SEL_SHADOW
    } spr_sel_e;

    typedef enum logic {
        ST_IDLE,
        ST_REDIRECT
    } redir_state_e;

endpackage

// File: rtl/spr_decode.sv
module spr_decode
    import spr_pkg::*;
#(
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned NUM_SPR     = 'h400,
    parameter int unsigned SHADOW_BASE = 'h100,
    parameter int unsigned SHADOW_N    = 512
) (
    input  logic [ADDR_W-1:0] addr,
    output spr_sel_e          sel,
    output logic              can_rd,
    output logic              can_wr
);
    int unsigned a;

    always_comb begin
        a   = int'(addr);
        sel = SEL_NONE;
        if (a < NUM_SPR) begin
            if (a >= SHADOW_BASE && a < SHADOW_BASE + SHADOW_N) begin
                sel = SEL_SHADOW;
            end else begin
                case (a)
                    A_VER:    sel = SEL_VER;
                    A_UNIT:   sel = SEL_UNIT;
                    A_CFG:    sel = SEL_CFG;
                    A_NPC:    sel = SEL_NPC;
                    A_STAT:   sel = SEL_STAT;
                    A_PPC:    sel = SEL_PPC;
                    A_FPC:    sel = SEL_FPC;
                    A_EPC:    sel = SEL_EPC;
                    A_ESR:    sel = SEL_ESR;
                    A_ACC_LO: sel = SEL_ACC_LO;
                    A_ACC_HI: sel = SEL_ACC_HI;
                    A_TMR:    sel = SEL_TMR;
                    default:  sel = SEL_NONE;
                endcase
            end
        end
    end

    always_comb begin
        can_rd = sel inside {SEL_VER, SEL_UNIT, SEL_CFG, SEL_STAT, SEL_PPC,
                             SEL_FPC, SEL_EPC, SEL_ACC_LO, SEL_ACC_HI, SEL_SHADOW};
        can_wr = sel inside {SEL_NPC, SEL_STAT, SEL_FPC, SEL_EPC, SEL_ESR,
                             SEL_ACC_LO, SEL_ACC_HI, SEL_TMR, SEL_SHADOW};
    end

endmodule

// File: rtl/spr_regs.sv
module spr_regs
    import spr_pkg::*;
#(
    parameter int unsigned SHADOW_N  = 512,
    parameter int unsigned FIX_BIT   = 15,
    parameter logic [31:0] VER_VAL   = 32'h1200_0001,
    parameter logic [31:0] UNIT_VAL  = 32'h0000_0641,
    parameter logic [31:0] CFG_VAL   = 32'h0000_0020,
    localparam int unsigned IDX_W    = $clog2(SHADOW_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  spr_sel_e          sel,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] prev_pc,
    output logic [DATA_W-1:0] rd_val
);
    localparam logic [DATA_W-1:0] FIX_MASK = DATA_W'(1) << FIX_BIT;

    logic [DATA_W-1:0] stat_q, fpc_q, epc_q, esr_q, acc_lo_q, acc_hi_q;
    logic [DATA_W-1:0] shadow_q [SHADOW_N];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q   <= FIX_MASK;
            fpc_q    <= '0;
            epc_q    <= '0;
            esr_q    <= '0;
            acc_lo_q <= '0;
            acc_hi_q <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_STAT:   stat_q   <= wdata | FIX_MASK;
                SEL_FPC:    fpc_q    <= wdata;
                SEL_EPC:    epc_q    <= wdata;
                SEL_ESR:    esr_q    <= wdata;
                SEL_ACC_LO: acc_lo_q <= wdata;
                SEL_ACC_HI: acc_hi_q <= wdata;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && sel == SEL_SHADOW) begin
            shadow_q[idx] <= wdata;
        end
    end

    always_comb begin
        case (sel)
            SEL_VER:    rd_val = VER_VAL;
            SEL_UNIT:   rd_val = UNIT_VAL;
            SEL_CFG:    rd_val = CFG_VAL;
            SEL_STAT:   rd_val = stat_q;
            SEL_PPC:    rd_val = prev_pc;
            SEL_FPC:    rd_val = fpc_q;
            SEL_EPC:    rd_val = epc_q;
            SEL_ACC_LO: rd_val = acc_lo_q;
            SEL_ACC_HI: rd_val = acc_hi_q;
            SEL_SHADOW: rd_val = shadow_q[idx];
            default:    rd_val = '0;
        endcase
    end

endmodule

// File: rtl/spr_redirect_fsm.sv
module spr_redirect_fsm
    import spr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              npc_wr,
    input  logic [DATA_W-1:0] npc_val,
    output logic              redirect_req,
    output logic [DATA_W-1:0] redirect_pc
);
    redir_state_e      state_q, state_d;
    logic [DATA_W-1:0] target_q;

    always_comb begin
        unique case (state_q)
            ST_IDLE:     state_d = npc_wr ? ST_REDIRECT : ST_IDLE;
            ST_REDIRECT: state_d = npc_wr ? ST_REDIRECT : ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            target_q <= '0;
        end else begin
            state_q <= state_d;
            if (npc_wr) begin
                target_q <= npc_val;
            end
        end
    end

    always_comb begin
        unique case (state_q)
            ST_REDIRECT: begin
                redirect_req = 1'b1;
                redirect_pc  = target_q;
            end
            default: begin
                redirect_req = 1'b0;
                redirect_pc  = '0;
            end
        endcase
    end

endmodule

// File: rtl/spr_access_ctrl.sv
module spr_access_ctrl
    import spr_pkg::*;
#(
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned NUM_SPR     = 'h400,
    parameter int unsigned SHADOW_BASE = 'h100,
    parameter int unsigned SHADOW_N    = 512,
    parameter int unsigned FIX_BIT     = 15,
    parameter logic [31:0] VER_VAL     = 32'h1200_0001,
    parameter logic [31:0] UNIT_VAL    = 32'h0000_0641,
    parameter logic [31:0] CFG_VAL     = 32'h0000_0020
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [31:0]       acc_wdata,
    input  logic              sr_super,
    input  logic              sr_user_spr,
    input  logic [31:0]       prev_pc,
    output logic [31:0]       rd_data,
    output logic              bad_access,
    output logic              redirect_req,
    output logic [31:0]       redirect_pc
);
    localparam int unsigned IDX_W = $clog2(SHADOW_N);

    spr_sel_e          sel;
    logic              can_rd, can_wr, priv, do_rd, do_wr, tmr_warn;
    logic [IDX_W-1:0]  shadow_idx;
    logic [ADDR_W-1:0] addr_off;
    logic [31:0]       rd_val;

    spr_decode #(
        .ADDR_W(ADDR_W), .NUM_SPR(NUM_SPR),
        .SHADOW_BASE(SHADOW_BASE), .SHADOW_N(SHADOW_N)
    ) u_dec (
        .addr(acc_addr), .sel(sel), .can_rd(can_rd), .can_wr(can_wr)
    );

    always_comb begin
        addr_off   = acc_addr - ADDR_W'(SHADOW_BASE);
        shadow_idx = addr_off[IDX_W-1:0];
        priv       = sr_super | sr_user_spr;
        do_rd      = acc_valid & ~acc_write & priv & can_rd;
        do_wr      = acc_valid &  acc_write & priv & can_wr;
        tmr_warn   = do_wr & (sel == SEL_TMR) & (|acc_wdata);
        bad_access = acc_valid & (~priv | (acc_write ? ~can_wr : ~can_rd) | tmr_warn);
        rd_data    = do_rd ? rd_val : '0;
    end

    spr_regs #(
        .SHADOW_N(SHADOW_N), .FIX_BIT(FIX_BIT),
        .VER_VAL(VER_VAL), .UNIT_VAL(UNIT_VAL), .CFG_VAL(CFG_VAL)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(do_wr), .sel(sel), .idx(shadow_idx),
        .wdata(acc_wdata), .prev_pc(prev_pc), .rd_val(rd_val)
    );

    spr_redirect_fsm u_redir (
        .clk(clk), .rst_n(rst_n),
        .npc_wr(do_wr && sel == SEL_NPC), .npc_val(acc_wdata),
        .redirect_req(redirect_req), .redirect_pc(redirect_pc)
    );

endmodule

// File: rtl/spr_access_chk.sv
module spr_access_chk
    import spr_pkg::*;
#(
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned NUM_SPR = 'h400,
    parameter int unsigned FIX_BIT = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [31:0]       acc_wdata,
    input logic              sr_super,
    input logic              sr_user_spr,
    input logic [31:0]       rd_data,
    input logic              bad_access,
    input logic              redirect_req,
    input logic [31:0]       redirect_pc
);
    logic priv_ok, npc_wr;
    assign priv_ok = sr_super | sr_user_spr;
    assign npc_wr  = acc_valid && acc_write && priv_ok && int'(acc_addr) == A_NPC;

    // R1
    priv_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !priv_ok |-> rd_data == '0 && bad_access);

    // R2
    out_of_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && int'(acc_addr) >= NUM_SPR |-> rd_data == '0 && bad_access);

    // R4
    esr_unreadable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !acc_write && priv_ok && int'(acc_addr) == A_ESR
        |-> rd_data == '0 && bad_access);

    // R6
    stat_fixed_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !acc_write && priv_ok && int'(acc_addr) == A_STAT
        |-> rd_data[FIX_BIT]);

    // R7
    redirect_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        npc_wr |=> redirect_req && redirect_pc == $past(acc_wdata));

    // R7
    redirect_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !npc_wr |=> !redirect_req);

    // R8
    tmr_zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_write && priv_ok && int'(acc_addr) == A_TMR && acc_wdata == '0
        |-> !bad_access);

    // R11
    write_no_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_write |-> rd_data == '0);

endmodule

bind spr_access_ctrl spr_access_chk #(
    .ADDR_W(ADDR_W), .NUM_SPR(NUM_SPR), .FIX_BIT(FIX_BIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .sr_super(sr_super),
    .sr_user_spr(sr_user_spr), .rd_data(rd_data), .bad_access(bad_access),
    .redirect_req(redirect_req), .redirect_pc(redirect_pc)
);

// File: tb/sim_spr_access_ctrl.sv
module sim_spr_access_ctrl;
    import spr_pkg::*;

    localparam logic [31:0] PPC_VAL = 32'h0000_4440;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0, acc_write = 1'b0;
    logic [11:0] acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic        sr_super = 1'b1, sr_user_spr = 1'b0;
    logic [31:0] rd_data, redirect_pc;
    logic        bad_access, redirect_req;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    spr_access_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .sr_super(sr_super),
        .sr_user_spr(sr_user_spr), .prev_pc(PPC_VAL), .rd_data(rd_data),
        .bad_access(bad_access), .redirect_req(redirect_req), .redirect_pc(redirect_pc)
    );

    typedef struct packed {
        logic        w;
        logic [11:0] a;
        logic [31:0] d;
        logic        s;
        logic        u;
        logic [31:0] e;
        logic        b;
        logic [3:0]  r;
    } vec_t;

    localparam int NV = 34;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 12'h00B, 32'hA5A5_0001, 1'b1, 1'b0, 32'h0, 1'b0, 4'd11}, // R11
        '{1'b0, 12'h00B, 32'h0,         1'b1, 1'b0, 32'hA5A5_0001, 1'b0, 4'd3}, // R3
        '{1'b1, 12'h00C, 32'h0000_2000, 1'b1, 1'b0, 32'h0, 1'b0, 4'd3},
        '{1'b0, 12'h00C, 32'h0,         1'b1, 1'b0, 32'h0000_2000, 1'b0, 4'd3},
        '{1'b1, 12'h010, 32'h1111_2222, 1'b1, 1'b0, 32'h0, 1'b0, 4'd3},
        '{1'b1, 12'h011, 32'h3333_4444, 1'b1, 1'b0, 32'h0, 1'b0, 4'd3},
        '{1'b0, 12'h010, 32'h0,         1'b1, 1'b0, 32'h1111_2222, 1'b0, 4'd3},
        '{1'b0, 12'h011, 32'h0,         1'b1, 1'b0, 32'h3333_4444, 1'b0, 4'd3},
        '{1'b1, 12'h009, 32'h0000_0003, 1'b1, 1'b0, 32'h0, 1'b0, 4'd6},  // R6
        '{1'b0, 12'h009, 32'h0,         1'b1, 1'b0, 32'h0000_8003, 1'b0, 4'd6},
        '{1'b1, 12'h00D, 32'hDEAD_BEEF, 1'b1, 1'b0, 32'h0, 1'b0, 4'd4},  // R4
        '{1'b0, 12'h00D, 32'h0,         1'b1, 1'b0, 32'h0, 1'b1, 4'd4},
        '{1'b1, 12'h000, 32'h0000_FFFF, 1'b1, 1'b0, 32'h0, 1'b1, 4'd5},  // R5
        '{1'b0, 12'h000, 32'h0,         1'b1, 1'b0, 32'h1200_0001, 1'b0, 4'd5},
        '{1'b0, 12'h001, 32'h0,         1'b1, 1'b0, 32'h0000_0641, 1'b0, 4'd3},
        '{1'b0, 12'h002, 32'h0,         1'b1, 1'b0, 32'h0000_0020, 1'b0, 4'd3},
        '{1'b1, 12'h100, 32'hCAFE_0000, 1'b1, 1'b0, 32'h0, 1'b0, 4'd9},  // R9
        '{1'b1, 12'h2FF, 32'h0BAD_F00D, 1'b1, 1'b0, 32'h0, 1'b0, 4'd9},
        '{1'b0, 12'h100, 32'h0,         1'b1, 1'b0, 32'hCAFE_0000, 1'b0, 4'd9},
        '{1'b0, 12'h2FF, 32'h0,         1'b1, 1'b0, 32'h0BAD_F00D, 1'b0, 4'd9},
        '{1'b1, 12'h018, 32'h0,         1'b1, 1'b0, 32'h0, 1'b0, 4'd8},  // R8
        '{1'b1, 12'h018, 32'h0000_0005, 1'b1, 1'b0, 32'h0, 1'b1, 4'd8},
        '{1'b0, 12'h018, 32'h0,         1'b1, 1'b0, 32'h0, 1'b1, 4'd8},
        '{1'b0, 12'h003, 32'h0,         1'b1, 1'b0, 32'h0, 1'b1, 4'd10}, // R10
        '{1'b1, 12'h300, 32'h1234_5678, 1'b1, 1'b0, 32'h0, 1'b1, 4'd10},
        '{1'b0, 12'h400, 32'h0,         1'b1, 1'b0, 32'h0, 1'b1, 4'd2},  // R2
        '{1'b1, 12'hFFF, 32'h5555_5555, 1'b1, 1'b0, 32'h0, 1'b1, 4'd2},
        '{1'b0, 12'h00B, 32'h0,         1'b0, 1'b1, 32'hA5A5_0001, 1'b0, 4'd1}, // R1
        '{1'b0, 12'h00B, 32'h0,         1'b0, 1'b0, 32'h0, 1'b1, 4'd1},
        '{1'b1, 12'h00B, 32'h0,         1'b0, 1'b0, 32'h0, 1'b1, 4'd1},
        '{1'b0, 12'h00B, 32'h0,         1'b1, 1'b0, 32'hA5A5_0001, 1'b0, 4'd1},
        '{1'b0, 12'h008, 32'h0,         1'b1, 1'b0, 32'h0, 1'b1, 4'd7},  // R7
        '{1'b0, 12'h00A, 32'h0,         1'b1, 1'b0, 32'h0000_4440, 1'b0, 4'd3},
        '{1'b1, 12'h00A, 32'h0000_0001, 1'b1, 1'b0, 32'h0, 1'b1, 4'd5}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic access(input logic w, input logic [11:0] a, input logic [31:0] d,
                          input logic s, input logic u);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = w; acc_addr = a; acc_wdata = d;
        sr_super = s; sr_user_spr = u;
        #5;
    endtask

    task automatic idle();
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; acc_addr = '0; acc_wdata = '0;
        sr_super = 1'b1; sr_user_spr = 1'b0;
        #5;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=%08h expected=%08h", 0, 1);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12: reset state
        idle();
        check(redirect_req == 1'b0, "R12", {31'b0, redirect_req}, 32'h0);
        access(1'b0, 12'h009, '0, 1'b1, 1'b0);
        check(rd_data == 32'h0000_8000, "R12", rd_data, 32'h0000_8000);
        access(1'b0, 12'h011, '0, 1'b1, 1'b0);
        check(rd_data == 32'h0, "R12", rd_data, 32'h0);
        access(1'b0, 12'h00B, '0, 1'b1, 1'b0);
        check(rd_data == 32'h0, "R12", rd_data, 32'h0);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            access(TBL[i].w, TBL[i].a, TBL[i].d, TBL[i].s, TBL[i].u);
            check(rd_data == TBL[i].e, $sformatf("R%0d rd vec%0d", TBL[i].r, i),
                  rd_data, TBL[i].e);
            check(bad_access == TBL[i].b, $sformatf("R%0d bad vec%0d", TBL[i].r, i),
                  {31'b0, bad_access}, {31'b0, TBL[i].b});
        end

        // R7: next-PC write gives a single redirect cycle
        access(1'b1, 12'h008, 32'h0000_8800, 1'b1, 1'b0);
        check(bad_access == 1'b0 && redirect_req == 1'b0, "R7", {31'b0, redirect_req}, 32'h0);
        idle();
        check(redirect_req == 1'b1, "R7", {31'b0, redirect_req}, 32'h1);
        check(redirect_pc == 32'h0000_8800, "R7", redirect_pc, 32'h0000_8800);
        idle();
        check(redirect_req == 1'b0, "R7", {31'b0, redirect_req}, 32'h0);

        // R7 back-to-back next-PC writes stay in the redirect state
        access(1'b1, 12'h008, 32'h0000_1000, 1'b1, 1'b0);
        access(1'b1, 12'h008, 32'h0000_2000, 1'b1, 1'b0);
        check(redirect_pc == 32'h0000_1000, "R7", redirect_pc, 32'h0000_1000);
        idle();
        check(redirect_req && redirect_pc == 32'h0000_2000, "R7", redirect_pc, 32'h0000_2000);
        idle();

        // R1: refused next-PC write raises no redirect
        access(1'b1, 12'h008, 32'h0000_3000, 1'b0, 1'b0);
        check(bad_access == 1'b1, "R1", {31'b0, bad_access}, 32'h1);
        idle();
        check(redirect_req == 1'b0, "R1", {31'b0, redirect_req}, 32'h0);

        // R8: timer writes left the status register untouched
        access(1'b0, 12'h009, '0, 1'b1, 1'b0);
        check(rd_data == 32'h0000_8003, "R8", rd_data, 32'h0000_8003);

        // R6: clearing every bit still leaves the fixed-one bit
        access(1'b1, 12'h009, 32'h0000_0000, 1'b1, 1'b0);
        access(1'b0, 12'h009, '0, 1'b1, 1'b0);
        check(rd_data == 32'h0000_8000, "R6", rd_data, 32'h0000_8000);

        idle();
        done = 1'b1;
        finish_run();
    end

endmodule